// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM Controller Model

This block models the clocked control path of a pipelined synchronous SRAM that needs no idle cycles when the bus turns between reads and writes. Each rising clock edge either opens a new access at the external address or continues the burst already running. A two-bit counter steps through the low address bits of a continuing burst. Write data arrives late, two edges after its address, and byte lane masks decide which bytes change. Read data leaves the output register two edges after its address was taken. The output has a separate enable. That enable drops whenever the slot on the bus is not a read, when the output enable is released, or when the sleep input is raised.

A host drives the pins as it would drive a discrete SRAM part. A low clock enable lets the edge act. A high clock enable inserts a wait state and the whole pipeline holds still. The storage is a small register array sized by parameters. It is cleared to zero on reset.

Top module: `nbt_sram_model`

## Requirements
- R1: During and after reset, and until a read reaches the output, `rdata_oe` is low. The array reads as all zeros after reset.
- R2: An edge with `adv` low and the chip selected (`ce1_n`=0, `ce2`=1, `ce3_n`=0) opens a burst at `addr`. `we_n` low makes it a write and `we_n` high makes it a read.
- R3: A read whose address is taken at edge k puts that word on `rdata` after edge k+2. `rdata_oe` is then high, provided `oe_n` is low and `sleep` is low.
- R4: For a write whose address is taken at edge k, `bw_n` is sampled at edge k and `wdata` is sampled at edge k+2. Byte lane i is `wdata[8i+7:8i]`, and it is stored only if `bw_n[i]` was low.
- R5: A write with every `bw_n` bit high is aborted and leaves the array unchanged.
- R6: An edge with `adv` high continues the running burst with the same read or write type. Its address keeps the upper bits, and its low two bits are (start + n) mod 4 on the n-th continue.
- R7: A continue edge that follows a deselect performs no access and gives no drive.
- R8: An edge with `adv` low and any chip-enable combination other than the selected one is a deselect. No access happens, and its output slot has `rdata_oe` low.
- R9: Output slots that belong to writes have `rdata_oe` low, even with `oe_n` held low.
- R10: With `cke_n` high the edge is ignored and all state holds. The output stays driven if it was showing a read and stays off if it was not.
- R11: `sleep` high forces `rdata_oe` low at once, without waiting for a clock edge, and edges seen while it is high are ignored.
- R12: `oe_n` high forces `rdata_oe` low at once and does not disturb the pipeline.
- R13: A read issued on the edge after a write to the same address returns the new write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Clock enable, low lets the edge act |
| adv | input | 1 | High continues the burst, low starts a new access |
| we_n | input | 1 | Low selects write on a new access |
| bw_n | input | BYTES | Active-low byte lane write enables |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, high forces output off and freezes |
| addr | input | ADDR_W | Word address of a new access |
| wdata | input | 8*BYTES | Late write data |
| rdata | output | 8*BYTES | Read data register |
| rdata_oe | output | 1 | Output drive enable for `rdata` |

## Verification
Two functions can meet in one cycle. The first is a late write committing its data while a read to the same word is issued on the very next edge (R13). The second is a stall or sleep landing just as a read or a write reaches the output slot (R10, R11). Directed alternating write/read pairs to one address provoke the first case. Clock-enable and sleep pulses, placed against reads and writes sitting in each pipeline stage, provoke the second, and a long random mix of all inputs covers both again. On every clock a behavioural queue model in the bench gives the expected drive and data, and a mismatch is reported under the requirement the current phase targets.

// File: rtl/nbt_pkg.sv
// Package nbt_pkg
// Shared operation encoding for the SRAM control model.
// Assumes: one operation slot enters the pipeline per acting edge.
package nbt_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_e;
endpackage

// File: rtl/nbt_burst_ctrl.sv
// Module nbt_burst_ctrl
// Decodes new-access and continue cycles, holds the running burst
// (type, upper address, 2-bit linear offset) and presents the slot to issue.
// Assumes: 'step' is high only on edges that act (clock enabled, not asleep).
module nbt_burst_ctrl
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              adv,
    input  logic              we_n,
    input  logic [BYTES-1:0]  bw_n,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output op_kind_e          iss_op,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [BYTES-1:0]  iss_mask
);
    localparam int HI_W = ADDR_W - 2;

    logic            run_q;
    logic            wr_q;
    logic [HI_W-1:0] hi_q;
    logic [1:0]      ofs_q;
    logic [1:0]      ofs_nx;

    assign ofs_nx = ofs_q + 2'd1;

    // Choose the operation for this edge: new access, continue, or nothing.
    always_comb begin
        iss_op   = OP_NONE;
        iss_addr = addr;
        if (!adv) begin
            if (sel) iss_op = we_n ? OP_READ : OP_WRITE;
        end else if (run_q) begin
            iss_op   = wr_q ? OP_WRITE : OP_READ;
            iss_addr = {hi_q, ofs_nx};
        end
        iss_mask = (iss_op == OP_WRITE) ? ~bw_n : '0;
    end

    // Track the running burst; a deselect ends it so later continues stay idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            wr_q  <= 1'b0;
            hi_q  <= '0;
            ofs_q <= '0;
        end else if (step) begin
            if (!adv) begin
                run_q <= sel;
                wr_q  <= !we_n;
                hi_q  <= addr[ADDR_W-1:2];
                ofs_q <= addr[1:0];
            end else if (run_q) begin
                ofs_q <= ofs_nx;
            end
        end
    end
endmodule

// File: rtl/nbt_pipe_mem.sv
// Module nbt_pipe_mem
// Two-stage slot pipeline, register array and read output register.
// A slot is executed when it leaves stage 2: writes take the wdata present
// at that edge, reads load the output register from the array.
// Assumes: 'step' freezes every register here when low.
module nbt_pipe_mem
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  op_kind_e             iss_op,
    input  logic [ADDR_W-1:0]    iss_addr,
    input  logic [BYTES-1:0]     iss_mask,
    input  logic [8*BYTES-1:0]   wdata,
    output logic [8*BYTES-1:0]   dout,
    output logic                 drive
);
    localparam int DW    = 8 * BYTES;
    localparam int DEPTH = 1 << ADDR_W;

    op_kind_e          s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [BYTES-1:0]  s1_mask, s2_mask;
    logic [DW-1:0]     mem [DEPTH];

    // Move slots through the two address stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op   <= OP_NONE;
            s2_op   <= OP_NONE;
            s1_addr <= '0;
            s2_addr <= '0;
            s1_mask <= '0;
            s2_mask <= '0;
        end else if (step) begin
            s1_op   <= iss_op;
            s1_addr <= iss_addr;
            s1_mask <= iss_mask;
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_mask <= s1_mask;
        end
    end

    // Commit late write data byte by byte; clear the array on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else if (step && s2_op == OP_WRITE) begin
            for (int b = 0; b < BYTES; b++)
                if (s2_mask[b]) mem[s2_addr][8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    // Load the output register for read slots; other slots turn drive off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= '0;
            drive <= 1'b0;
        end else if (step) begin
            drive <= (s2_op == OP_READ);
            if (s2_op == OP_READ) dout <= mem[s2_addr];
        end
    end
endmodule

// File: rtl/nbt_sram_model.sv
// Module nbt_sram_model (top)
// Control model of a pipelined synchronous SRAM with no bus turnaround.
// Assumes: all inputs but oe_n and sleep are meant for the rising edge;
// oe_n and sleep act combinationally on the output enable.
module nbt_sram_model
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4,
    parameter int DATA_W = 8 * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              adv,
    input  logic              we_n,
    input  logic [BYTES-1:0]  bw_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);
    logic              step;
    logic              sel;
    logic              drive;
    op_kind_e          iss_op;
    logic [ADDR_W-1:0] iss_addr;
    logic [BYTES-1:0]  iss_mask;

    assign step     = !cke_n && !sleep;
    assign sel      = !ce1_n && ce2 && !ce3_n;
    assign rdata_oe = drive && !oe_n && !sleep;

    nbt_burst_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) burst_i (
        .clk(clk), .rst_n(rst_n), .step(step), .adv(adv), .we_n(we_n),
        .bw_n(bw_n), .sel(sel), .addr(addr),
        .iss_op(iss_op), .iss_addr(iss_addr), .iss_mask(iss_mask)
    );

    nbt_pipe_mem #(.ADDR_W(ADDR_W), .BYTES(BYTES)) pipe_i (
        .clk(clk), .rst_n(rst_n), .step(step), .iss_op(iss_op),
        .iss_addr(iss_addr), .iss_mask(iss_mask), .wdata(wdata),
        .dout(rdata), .drive(drive)
    );
endmodule

// File: rtl/nbt_sram_chk.sv
// Module nbt_sram_chk
// Port-level checker for nbt_sram_model, attached by bind below.
// Assumes: synchronous active-low reset on rst_n.
module nbt_sram_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_n,
    input logic              adv,
    input logic              we_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              oe_n,
    input logic              sleep,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe
);
    logic act;
    logic sel;
    assign act = !cke_n && !sleep;
    assign sel = !ce1_n && ce2 && !ce3_n;

    assert_sleep_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rdata_oe);

    assert_oe_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_oe);

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable(rdata));

    assert_write_slot_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $past(act) && $past(act, 2) &&
         $past(!adv && sel && !we_n, 2)) |=> !rdata_oe);

    assert_read_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $past(act) && $past(act, 2) &&
         $past(!adv && sel && we_n, 2)) |=> (oe_n || sleep || rdata_oe));

    assert_desel_continue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $past(act) && $past(act, 2) && $past(act, 3) &&
         $past(!adv && !sel, 3) && $past(adv, 2)) |=> !rdata_oe);
endmodule

bind nbt_sram_model nbt_sram_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv(adv), .we_n(we_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .oe_n(oe_n), .sleep(sleep),
    .rdata(rdata), .rdata_oe(rdata_oe)
);

// File: tb/nbt_sram_model_tb_top.sv
// Bench for nbt_sram_model: behavioural queue model compared every clock.
module nbt_sram_model_tb_top;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = 8 * NB;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b0, adv = 1'b0, we_n = 1'b1;
    logic [NB-1:0] bw_n = '1;
    logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic          oe_n = 1'b0, sleep = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    int total = 0, bad = 0, cycles = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    nbt_sram_model #(.ADDR_W(AW), .BYTES(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv(adv), .we_n(we_n),
        .bw_n(bw_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .oe_n(oe_n),
        .sleep(sleep), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rdata_oe(rdata_oe)
    );

    // Reference model: 0 none, 1 read, 2 write, held in FIFO queues.
    int          q_kind[$];
    int          q_addr[$];
    int          q_mask[$];
    logic [DW-1:0] ref_mem [NW];
    bit          m_run, m_wr, exp_drive;
    int          m_base, m_ofs;
    logic [DW-1:0] exp_data;

    task automatic model_reset();
        q_kind = '{0, 0}; q_addr = '{0, 0}; q_mask = '{0, 0};
        for (int i = 0; i < NW; i++) ref_mem[i] = '0;
        m_run = 0; m_wr = 0; m_base = 0; m_ofs = 0;
        exp_drive = 0; exp_data = '0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else if (!cke_n && !sleep) begin
            int k, a, m, nk, na, nm;
            k = q_kind.pop_front(); a = q_addr.pop_front(); m = q_mask.pop_front();
            if (k == 2) begin
                for (int b = 0; b < NB; b++)
                    if (m[b]) ref_mem[a][8*b +: 8] = wdata[8*b +: 8];
                exp_drive = 0;
            end else if (k == 1) begin
                exp_drive = 1; exp_data = ref_mem[a];
            end else exp_drive = 0;
            nk = 0; na = 0; nm = 0;
            if (!adv) begin
                if (!ce1_n && ce2 && !ce3_n) begin
                    nk = we_n ? 1 : 2; na = int'(addr);
                    m_run = 1; m_wr = !we_n; m_base = int'(addr) / 4 * 4; m_ofs = int'(addr) % 4;
                end else m_run = 0;
            end else if (m_run) begin
                m_ofs = (m_ofs + 1) % 4;
                nk = m_wr ? 2 : 1; na = m_base + m_ofs;
            end
            if (nk == 2) nm = int'(~bw_n);
            q_kind.push_back(nk); q_addr.push_back(na); q_mask.push_back(nm);
        end
    end

    task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare outputs on every falling edge, once reset is released.
    always @(negedge clk) begin
        if (rst_n) begin
            bit eo;
            eo = exp_drive && !oe_n && !sleep;
            check(rdata_oe == eo, phase, "rdata_oe", DW'(rdata_oe), DW'(eo));
            if (eo) check(rdata == exp_data, phase, "rdata", rdata, exp_data);
        end
    end

    // One bus cycle; sel picks the selected chip-enable pattern or a deselect one.
    task automatic cyc(bit a, bit w, logic [NB-1:0] b, bit s, int ad);
        @(negedge clk);
        adv = a; we_n = w; bw_n = b; addr = AW'(ad); wdata = $urandom;
        if (s) begin ce1_n = 0; ce2 = 1; ce3_n = 0; end
        else begin ce1_n = 1; ce2 = 0; ce3_n = 1; end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 1, '1, 0, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rdata_oe == 1'b0, "R1", "oe in reset", DW'(rdata_oe), '0);
        @(negedge clk); rst_n = 1;
        phase = "R1"; idle(3);
        cyc(0, 1, '1, 1, 33); idle(3);             // R1 zero array read
        phase = "R2"; cyc(0, 0, '0, 1, 5);          // R2 write burst at 5
        phase = "R6"; cyc(1, 1, '0, 0, 0); cyc(1, 1, '0, 0, 0); cyc(1, 1, '0, 0, 0);
        phase = "R3"; cyc(0, 1, '1, 1, 4);          // R3 read burst 4..7
        cyc(1, 0, '1, 0, 0); cyc(1, 0, '1, 0, 0); cyc(1, 0, '1, 0, 0);
        phase = "R6"; cyc(0, 1, '1, 1, 7); cyc(1, 1, '1, 1, 0); idle(3); // wrap
        phase = "R13";
        for (int i = 0; i < 6; i++) begin cyc(0, 0, '0, 1, 10 + i % 2); cyc(0, 1, '1, 1, 10 + i % 2); end
        idle(3);
        phase = "R5"; cyc(0, 0, '1, 1, 10); cyc(0, 1, '1, 1, 10); idle(3);
        phase = "R4"; cyc(0, 0, 4'b1010, 1, 10); cyc(0, 1, '1, 1, 10); idle(3);
        phase = "R8";
        @(negedge clk); adv = 0; we_n = 1; addr = 4; ce1_n = 0; ce2 = 0; ce3_n = 0;
        @(negedge clk); ce2 = 1; ce3_n = 1;
        @(negedge clk); ce1_n = 1; ce3_n = 0;
        idle(3);
        phase = "R7"; idle(1); cyc(1, 1, '1, 1, 4); cyc(1, 0, '0, 1, 4); idle(3);
        phase = "R9"; cyc(0, 1, '1, 1, 4); cyc(0, 0, '0, 1, 20); cyc(0, 1, '1, 1, 20); idle(3);
        phase = "R10";
        cyc(0, 1, '1, 1, 5); cyc(1, 1, '1, 0, 0); cyc(1, 1, '1, 0, 0);
        @(negedge clk); cke_n = 1; @(negedge clk); @(negedge clk); cke_n = 0;
        cyc(0, 0, '0, 1, 21); cyc(1, 0, '0, 0, 0); cyc(1, 0, '0, 0, 0);
        @(negedge clk); cke_n = 1; @(negedge clk); cke_n = 0;
        cyc(0, 1, '1, 1, 21); cyc(1, 1, '1, 0, 0); idle(3);
        phase = "R11";
        cyc(0, 1, '1, 1, 4); cyc(1, 1, '1, 0, 0); cyc(1, 1, '1, 0, 0);
        @(negedge clk); sleep = 1; #2; check(rdata_oe == 1'b0, "R11", "async sleep", DW'(rdata_oe), '0);
        @(negedge clk); sleep = 0; idle(4);
        phase = "R12";
        cyc(0, 1, '1, 1, 5); cyc(1, 1, '1, 0, 0); cyc(1, 1, '1, 0, 0);
        @(negedge clk); oe_n = 1; #2; check(rdata_oe == 1'b0, "R12", "async oe", DW'(rdata_oe), '0);
        @(negedge clk); oe_n = 0; idle(4);
        phase = "R6";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            adv = $urandom_range(0, 2) == 0; we_n = $urandom; bw_n = $urandom;
            addr = $urandom; wdata = $urandom;
            ce1_n = $urandom_range(0, 5) == 0; ce2 = $urandom_range(0, 5) != 0;
            ce3_n = $urandom_range(0, 5) == 0;
            cke_n = $urandom_range(0, 7) == 0; sleep = $urandom_range(0, 19) == 0;
            oe_n = $urandom_range(0, 9) == 0;
        end
        @(negedge clk); cke_n = 0; sleep = 0; oe_n = 0;
        idle(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule